// File: doc/BRIEF.md
# Interrupt pending/mask register bank

This block gathers seventeen single-cycle event pulses from a communications peripheral into a sticky pending register. A mask register selects which pending bits may raise the peripheral's one level-sensitive interrupt line. Software sees the block through a plain word-addressed read/write port. That port offers six register views, laid out at consecutive word offsets.

Two read views clear every pending bit as a side effect: the raw pending view and the masked pending view. Two further views return the same data without clearing anything. A write to the raw pending view can only add bits, never remove them. Selective clearing goes through a separate write-one-to-clear register. An event that lands in the same cycle as a clearing access always survives it.

Pending bit positions are fixed, counting down from the top: bit 16 tx loss, 15 rx miss, 14 tx error counter, 13 rx error counter, 12 tx sync, 11 rx sync, 10 tx, 9 rx, 8 tx empty, 7 rx full, 6 tx irq, 5 rx irq, 4 tx bus error, 3 rx bus error, 2 overrun, 1 bus-off, 0 pass.

Top module: `irq_bank`

## Requirements
- R1: A high on `evt_i[n]` at a rising clock edge sets pending bit n at that edge, and the bit stays set until software clears it.
- R2: After synchronous reset the pending and mask registers are zero, `irq_o` is low and `reg_rdata` is zero.
- R3: A read at offset 0 (raw pending, clearing) returns the pending bits and clears all of them at the same edge.
- R4: A read at offset 1 (masked pending, clearing) returns pending AND mask and clears every pending bit, masked ones included.
- R5: A write at offset 0 sets pending to its old value OR the write data, so a write never clears a bit.
- R6: A write at offset 5 (clear register) clears each pending bit whose write-data bit is one and leaves the others unchanged.
- R7: A read at offset 2 (status) returns the pending bits and leaves them unchanged.
- R8: A read at offset 3 (masked status) returns pending AND mask and leaves the pending bits unchanged.
- R9: Offset 4 is the mask register: a write stores the data, and a read returns the stored value.
- R10: `irq_o` is a register that takes the OR of (pending AND mask) one clock after that value is present.
- R11: Bits 31..17 read as zero in every view and ignore writes. Offsets 5, 6 and 7 read as zero.
- R12: An event bit that is high in the same cycle as a clearing read or a clear-register write is set after that edge.
- R13: `reg_rdata` is loaded at the edge where `reg_rd` is high and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 17 | Single-cycle event pulses, one per pending bit |
| reg_addr | input | 3 | Word offset of the register view |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered module interrupt line |

## Verification
An event or a write changes the pending and mask state at the edge where it is presented, so any read issued afterwards sees the change. Read data appears one edge after the read strobe, and the bench samples it on the falling edge that follows. The interrupt line needs one more edge than the state it is built from. The bench therefore checks `irq_o` one falling edge after the change, where it must still hold its old value, and again one falling edge later, where it must show the new value. Each access is held for a single rising edge, with the sample taken half a cycle later, so no result depends on the order of events at a clock edge.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  // Word offsets of the register views
  localparam int OFS_PEND     = 0;  // raw pending, clear on read, OR on write
  localparam int OFS_PEND_MSK = 1;  // masked pending, clear on read
  localparam int OFS_STAT     = 2;  // raw pending, no side effect
  localparam int OFS_STAT_MSK = 3;  // masked pending, no side effect
  localparam int OFS_MASK     = 4;  // mask register
  localparam int OFS_CLR      = 5;  // write-one-to-clear, reads zero

  // Pending bit positions
  localparam int SRC_PASS      = 0;
  localparam int SRC_BUSOFF    = 1;
  localparam int SRC_OVERRUN   = 2;
  localparam int SRC_RX_BUSERR = 3;
  localparam int SRC_TX_BUSERR = 4;
  localparam int SRC_RX_IRQ    = 5;
  localparam int SRC_TX_IRQ    = 6;
  localparam int SRC_RX_FULL   = 7;
  localparam int SRC_TX_EMPTY  = 8;
  localparam int SRC_RX        = 9;
  localparam int SRC_TX        = 10;
  localparam int SRC_RX_SYNC   = 11;
  localparam int SRC_TX_SYNC   = 12;
  localparam int SRC_RX_ECNT   = 13;
  localparam int SRC_TX_ECNT   = 14;
  localparam int SRC_RX_MISS   = 15;
  localparam int SRC_TX_LOSS   = 16;
  localparam int SRC_COUNT     = 17;
endpackage

// File: rtl/irq_bank_pending.sv
module irq_bank_pending #(
  parameter int NUM_SRC = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_all,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic [NUM_SRC-1:0] set_bits,
  output logic [NUM_SRC-1:0] pend_q
);
  // One sticky flop per source; a new event beats any clear in the same cycle.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic nxt;
    always_comb begin
      nxt = pend_q[b];
      if (clr_all || clr_bits[b]) nxt = 1'b0;
      if (set_bits[b] || evt[b])  nxt = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) pend_q[b] <= 1'b0;
      else     pend_q[b] <= nxt;
    end
  end
endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask #(
  parameter int NUM_SRC = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= wdata;
  end
endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 17,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [NUM_SRC-1:0] view;
  logic [DATA_W-1:0]  view_ext;

  always_comb begin
    view = '0;
    if (addr == ADDR_W'(OFS_PEND) || addr == ADDR_W'(OFS_STAT))
      view = pend;
    else if (addr == ADDR_W'(OFS_PEND_MSK) || addr == ADDR_W'(OFS_STAT_MSK))
      view = pend & mask;
    else if (addr == ADDR_W'(OFS_MASK))
      view = mask;
  end

  if (DATA_W > NUM_SRC) begin : g_pad
    assign view_ext = {{(DATA_W-NUM_SRC){1'b0}}, view};
  end else begin : g_nopad
    assign view_ext = view[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= view_ext;
  end
endmodule

// File: rtl/irq_bank_line.sv
module irq_bank_line #(
  parameter int NUM_SRC = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] mask,
  output logic               irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & mask);
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 17,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rd,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] wr_bits;
  logic               rd_clear;
  logic               wr_pend;
  logic               wr_mask;
  logic               wr_clr;

  assign wr_bits  = reg_wdata[NUM_SRC-1:0];
  assign rd_clear = reg_rd && (reg_addr == ADDR_W'(OFS_PEND) ||
                               reg_addr == ADDR_W'(OFS_PEND_MSK));
  assign wr_pend  = reg_wr && (reg_addr == ADDR_W'(OFS_PEND));
  assign wr_mask  = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));
  assign wr_clr   = reg_wr && (reg_addr == ADDR_W'(OFS_CLR));

  if (DATA_W > NUM_SRC) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^reg_wdata[DATA_W-1:NUM_SRC];
  end

  irq_bank_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_i),
    .clr_all  (rd_clear),
    .clr_bits (wr_clr ? wr_bits : '0),
    .set_bits (wr_pend ? wr_bits : '0),
    .pend_q   (pend_q)
  );

  irq_bank_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_mask),
    .wdata  (wr_bits),
    .mask_q (mask_q)
  );

  irq_bank_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd      (reg_rd),
    .addr    (reg_addr),
    .pend    (pend_q),
    .mask    (mask_q),
    .rdata_q (reg_rdata)
  );

  irq_bank_line #(.NUM_SRC(NUM_SRC)) u_line (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend_q),
    .mask  (mask_q),
    .irq_q (irq_o)
  );
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 17,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q
);
  p_reset_state_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '0 && pend_q == '0 && !irq_o));

  p_event_sticks_r1: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  p_clear_read_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_PEND) && !reg_wr && evt_i == '0) |=> (pend_q == '0));

  p_masked_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_PEND_MSK) && !reg_wr && evt_i == '0) |=> (pend_q == '0));

  p_or_write_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_PEND) && !reg_rd) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_status_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFS_STAT) && !reg_wr) |=> (pend_q == ($past(pend_q) | $past(evt_i))));

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(pend_q) & $past(mask_q))));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:NUM_SRC] == '0);

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind irq_bank irq_bank_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .pend_q    (pend_q),
  .mask_q    (mask_q)
);

// File: tb/irq_bank_bench.sv
module irq_bank_bench;
  localparam int NUM_SRC = 17;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;

  // op: 0 write, 1 read and check, 2 event pulse (data = event bits)
  // entry: {req[7:0], op[1:0], addr[2:0], data[31:0], exp[31:0]}
  localparam int VW = 77;
  localparam int NV = 24;
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'd2,  2'd1, 3'd2, 32'h0,          32'h0},          // R2 status zero
    {8'd2,  2'd1, 3'd4, 32'h0,          32'h0},          // R2 mask zero
    {8'd1,  2'd2, 3'd0, 32'h00000005,   32'h0},          // R1 events 0,2
    {8'd1,  2'd1, 3'd2, 32'h0,          32'h00000005},   // R1
    {8'd7,  2'd1, 3'd2, 32'h0,          32'h00000005},   // R7 no clear
    {8'd9,  2'd0, 3'd4, 32'hFFFF0004,   32'h0},          // R9 mask write
    {8'd11, 2'd1, 3'd4, 32'h0,          32'h00010004},   // R11 high ignored
    {8'd8,  2'd1, 3'd3, 32'h0,          32'h00000004},   // R8
    {8'd8,  2'd1, 3'd3, 32'h0,          32'h00000004},   // R8 no clear
    {8'd5,  2'd0, 3'd0, 32'hFFFF0100,   32'h0},          // R5 OR write
    {8'd5,  2'd0, 3'd0, 32'h00000000,   32'h0},          // R5 zero write
    {8'd5,  2'd1, 3'd2, 32'h0,          32'h00010105},   // R5
    {8'd6,  2'd0, 3'd5, 32'h00000101,   32'h0},          // R6 W1C
    {8'd6,  2'd1, 3'd2, 32'h0,          32'h00010004},   // R6
    {8'd4,  2'd1, 3'd1, 32'h0,          32'h00010004},   // R4 masked read
    {8'd4,  2'd1, 3'd2, 32'h0,          32'h0},          // R4 cleared
    {8'd1,  2'd2, 3'd0, 32'h00018000,   32'h0},          // R1 bits 15,16
    {8'd3,  2'd1, 3'd0, 32'h0,          32'h00018000},   // R3
    {8'd3,  2'd1, 3'd2, 32'h0,          32'h0},          // R3 cleared
    {8'd4,  2'd2, 3'd0, 32'h00000003,   32'h0},          // R4 masked-out bits
    {8'd4,  2'd1, 3'd1, 32'h0,          32'h0},          // R4 returns masked
    {8'd4,  2'd1, 3'd2, 32'h0,          32'h0},          // R4 masked bits cleared
    {8'd11, 2'd1, 3'd5, 32'h0,          32'h0},          // R11 clear reg reads 0
    {8'd11, 2'd1, 3'd7, 32'h0,          32'h0}           // R11 spare offset
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] evt_i = '0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic               reg_wr = 1'b0;
  logic [DATA_W-1:0]  reg_wdata = '0;
  logic               reg_rd = 1'b0;
  logic [DATA_W-1:0]  reg_rdata;
  logic               irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irq_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Each access lasts one rising edge; caller is at a falling edge.
  task automatic do_write(input int a, input logic [DATA_W-1:0] d);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(input int a, output logic [DATA_W-1:0] d);
    reg_addr = ADDR_W'(a); reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_event(input logic [NUM_SRC-1:0] e);
    evt_i = e;
    @(posedge clk); @(negedge clk);
    evt_i = '0;
  endtask

  initial begin
    logic [DATA_W-1:0] rd_val;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state at the ports
    check("R2 irq", {31'b0, irq_o}, 32'h0);
    check("R2 rdata", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]        req;
      logic [1:0]        op;
      logic [2:0]        a;
      logic [DATA_W-1:0] d, e;
      {req, op, a, d, e} = VEC[i];
      case (op)
        2'd0: do_write(int'(a), d);
        2'd1: begin
          do_read(int'(a), rd_val);
          check($sformatf("R%0d vec %0d", req, i), rd_val, e);
        end
        default: do_event(d[NUM_SRC-1:0]);
      endcase
    end

    // R10: mask is 0x10004, pending empty. Event on bit 2.
    evt_i = 17'h00004;
    @(posedge clk); @(negedge clk);
    evt_i = '0;
    check("R10 irq lags pending", {31'b0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R10 irq rises", {31'b0, irq_o}, 32'h1);

    // R12: event on bit 2 again during a clearing raw read
    evt_i = 17'h00004;
    reg_addr = 3'd0; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0; evt_i = '0;
    check("R3 read value", reg_rdata, 32'h00000004);
    do_read(2, rd_val);
    check("R12 event survives clearing read", rd_val, 32'h00000004);
    check("R10 irq stays with surviving bit", {31'b0, irq_o}, 32'h1);

    // R12: event on bit 2 with a clear-register write of the same bit
    evt_i = 17'h00004;
    reg_addr = 3'd5; reg_wdata = 32'h4; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; evt_i = '0;
    do_read(2, rd_val);
    check("R12 event survives W1C", rd_val, 32'h00000004);

    // R13: read data holds while idle
    repeat (3) @(negedge clk);
    check("R13 rdata hold", reg_rdata, 32'h00000004);

    // R10: clearing drops irq one edge after pending empties
    do_write(5, 32'h4);
    check("R10 irq one edge late", {31'b0, irq_o}, 32'h1);
    @(posedge clk); @(negedge clk);
    check("R10 irq falls", {31'b0, irq_o}, 32'h0);

    // R10: masked-off pending bit leaves irq low
    do_event(17'h00001);
    @(posedge clk); @(negedge clk);
    check("R10 masked source no irq", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule